// File: doc/BRIEF.md
# ARP Message Transmitter, 64-bit Byte-Lane Stream

This block turns one ARP message, handed over as a set of decoded fields on a valid/ready handshake, into an outgoing Ethernet frame. The frame leaves in two parts. First comes an Ethernet header handshake that carries the destination MAC, the source MAC and the ARP Ethertype. Then comes the 28-byte ARP body as a 64-bit byte-lane stream with data, keep, valid, ready and last. The block fills in the fixed protocol constants: hardware type 1, protocol type 0x0800, address lengths 6 and 4. The caller supplies only the operation code and the four addresses.

The block handles one message at a time. The field registers are loaded only when the input handshake completes. They stay frozen until the final body beat has been taken downstream, so the caller may change its inputs freely in the meantime. The input becomes ready again in the same cycle as the final beat transfer. A steady stream of messages therefore runs with no idle cycle between frames. The block does not compute a frame check sequence, does not pad the frame, and does not decide what to send.

Top module: `arp_frame_tx`

## Requirements
- R1: After reset, and in any cycle with no message in flight: `msg_ready` is 1, `hdr_valid` is 0, `body_tvalid` is 0 and `busy` is 0. A reset during a frame abandons that frame.
- R2: The message fields are captured only in a cycle where `msg_valid` and `msg_ready` are both 1. `msg_ready` is 0 from the cycle after capture until the cycle of the final body beat transfer. Input changes in between have no effect on any output.
- R3: The cycle after capture, `hdr_valid` rises. It presents the captured destination and source MAC, with `hdr_ethertype` = 16'h0806, all held stable until `hdr_ready` is 1.
- R4: Body beats start the cycle after the header transfer and never overlap it. A frame has exactly four body beats, numbered 0 to 3.
- R5: The body byte sequence is: hardware type (2), protocol type (2), hardware length (1), protocol length (1), operation (2), sender MAC (6), sender IP (4), target MAC (6), target IP (4). Every multi-byte field goes most significant byte first. Body byte k goes out in beat k/8, lane k%8, which is bits [8*(k%8)+7 : 8*(k%8)].
- R6: The constants are hardware type 16'h0001, protocol type 16'h0800, hardware length 8'd6 and protocol length 8'd4. With operation 16'h0002, beat 0 is therefore 64'h0200_0406_0008_0100.
- R7: Beats 0 to 2 have `body_tkeep` = 8'hFF and `body_tlast` = 0. Beat 3 has `body_tkeep` = 8'h0F, `body_tlast` = 1, and zeros in lanes 4 to 7.
- R8: While `body_tvalid` is 1 and `body_tready` is 0, the next cycle keeps `body_tvalid`, `body_tdata`, `body_tkeep` and `body_tlast` unchanged.
- R9: `busy` is 1 from the cycle after capture through the cycle of the final beat transfer. It stays 1 when a new message is captured in that same cycle.
- R10: In the cycle of the final beat transfer `msg_ready` is 1. A message captured there has its header valid in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| msg_valid | input | 1 | Message fields are valid |
| msg_ready | output | 1 | Block can take a message this cycle |
| msg_dst_mac | input | 48 | Ethernet destination MAC |
| msg_src_mac | input | 48 | Ethernet source MAC |
| msg_oper | input | 16 | ARP operation code |
| msg_sender_mac | input | 48 | Sender hardware address |
| msg_sender_ip | input | 32 | Sender protocol address |
| msg_target_mac | input | 48 | Target hardware address |
| msg_target_ip | input | 32 | Target protocol address |
| hdr_valid | output | 1 | Ethernet header is valid |
| hdr_ready | input | 1 | Downstream takes the header |
| hdr_dst_mac | output | 48 | Header destination MAC |
| hdr_src_mac | output | 48 | Header source MAC |
| hdr_ethertype | output | 16 | Header Ethertype, always 16'h0806 |
| body_tdata | output | 64 | Body beat data, lane 0 first on the wire |
| body_tkeep | output | 8 | Valid byte lanes of the beat |
| body_tvalid | output | 1 | Body beat is valid |
| body_tready | input | 1 | Downstream takes the beat |
| body_tlast | output | 1 | Final beat of the body |
| busy | output | 1 | A message is in flight |

## Verification
The assertions check, on every cycle, the rules that link the handshakes. They cover the header-before-body order and the header/body exclusion. They check that the header and beats are held while stalled, that keep matches last, that ready stays low mid-frame, and that the back-to-back restart goes straight to the header. The byte placement of each field, the constants in the body, and proof that input changes during a frame leave the output untouched can only be shown by the bench scenarios. The bench compares every beat against an independently built byte list under continuous-ready, random-stall and mid-frame-reset patterns.

// File: rtl/arp_tx_pkg.sv
package arp_tx_pkg;

  localparam int BODY_BYTES = 28;
  localparam int BODY_W     = BODY_BYTES * 8;

  localparam logic [15:0] ETYPE_ARP      = 16'h0806;
  localparam logic [15:0] HW_TYPE_ETHER  = 16'h0001;
  localparam logic [15:0] PROTO_TYPE_IP4 = 16'h0800;
  localparam logic [7:0]  HW_ADDR_BYTES  = 8'd6;
  localparam logic [7:0]  IP_ADDR_BYTES  = 8'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_BODY = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic [47:0] dst_mac;
    logic [47:0] src_mac;
    logic [15:0] oper;
    logic [47:0] sha;
    logic [31:0] spa;
    logic [47:0] tha;
    logic [31:0] tpa;
  } arp_msg_t;

  // Whole body as one vector, body byte 0 in the top byte.
  function automatic logic [BODY_W-1:0] body_image(arp_msg_t m);
    return {HW_TYPE_ETHER, PROTO_TYPE_IP4, HW_ADDR_BYTES, IP_ADDR_BYTES,
            m.oper, m.sha, m.spa, m.tha, m.tpa};
  endfunction

  // Body byte number idx (0 = first on the wire).
  function automatic logic [7:0] body_byte(logic [BODY_W-1:0] img, int idx);
    return img[BODY_W-1-8*idx -: 8];
  endfunction

endpackage

// File: rtl/arp_tx_capture.sv
module arp_tx_capture
  import arp_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  arp_msg_t msg_in,
  output arp_msg_t msg_q
);

  always_ff @(posedge clk) begin
    if (rst)       msg_q <= '0;
    else if (load) msg_q <= msg_in;
  end

endmodule

// File: rtl/arp_tx_ctrl.sv
module arp_tx_ctrl
  import arp_tx_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             msg_valid,
  input  logic             hdr_ready,
  input  logic             beat_ready,
  output logic             msg_ready,
  output logic             msg_load,
  output logic             hdr_valid,
  output logic             hdr_fire,
  output logic             beat_valid,
  output logic             beat_fire,
  output logic             beat_last,
  output logic             frame_done,
  output logic [CNT_W-1:0] beat_idx,
  output logic             busy
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

  tx_state_e        state_q, state_n;
  logic [CNT_W-1:0] beat_q;
  logic             at_last;

  assign at_last    = (beat_q == LAST_IDX);
  assign hdr_valid  = (state_q == ST_HDR);
  assign beat_valid = (state_q == ST_BODY);
  assign hdr_fire   = hdr_valid && hdr_ready;
  assign beat_fire  = beat_valid && beat_ready;
  assign frame_done = beat_fire && at_last;
  assign beat_last  = beat_valid && at_last;
  assign msg_ready  = (state_q == ST_IDLE) || frame_done;
  assign msg_load   = msg_valid && msg_ready;
  assign busy       = (state_q != ST_IDLE);
  assign beat_idx   = beat_q;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: if (msg_load)   state_n = ST_HDR;
      ST_HDR:  if (hdr_fire)   state_n = ST_BODY;
      ST_BODY: if (frame_done) state_n = msg_load ? ST_HDR : ST_IDLE;
      default:                 state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_n;
      if (hdr_fire)
        beat_q <= '0;
      else if (beat_fire && !at_last)
        beat_q <= beat_q + 1'b1;
    end
  end

endmodule

// File: rtl/arp_tx_beat_mux.sv
module arp_tx_beat_mux
  import arp_tx_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 2
) (
  input  logic [BODY_W-1:0]   img,
  input  logic [CNT_W-1:0]    beat_idx,
  output logic [DATA_W-1:0]   tdata,
  output logic [DATA_W/8-1:0] tkeep
);

  localparam int KEEP_W = DATA_W / 8;

  always_comb begin
    tdata = '0;
    tkeep = '0;
    for (int lane = 0; lane < KEEP_W; lane++) begin
      int idx;
      idx = int'(beat_idx) * KEEP_W + lane;
      if (idx < BODY_BYTES) begin
        tdata[8*lane +: 8] = body_byte(img, idx);
        tkeep[lane]        = 1'b1;
      end
    end
  end

endmodule

// File: rtl/arp_frame_tx.sv
module arp_frame_tx
  import arp_tx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [47:0]       msg_dst_mac,
  input  logic [47:0]       msg_src_mac,
  input  logic [15:0]       msg_oper,
  input  logic [47:0]       msg_sender_mac,
  input  logic [31:0]       msg_sender_ip,
  input  logic [47:0]       msg_target_mac,
  input  logic [31:0]       msg_target_ip,
  output logic              hdr_valid,
  input  logic              hdr_ready,
  output logic [47:0]       hdr_dst_mac,
  output logic [47:0]       hdr_src_mac,
  output logic [15:0]       hdr_ethertype,
  output logic [DATA_W-1:0] body_tdata,
  output logic [DATA_W/8-1:0] body_tkeep,
  output logic              body_tvalid,
  input  logic              body_tready,
  output logic              body_tlast,
  output logic              busy
);

  localparam int KEEP_W = DATA_W / 8;
  localparam int BEATS  = (BODY_BYTES + KEEP_W - 1) / KEEP_W;
  localparam int CNT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;

  // Internal events, brought out by name for the checker.
  logic             msg_load;
  logic             hdr_fire;
  logic             beat_fire;
  logic             frame_done;
  logic [CNT_W-1:0] beat_idx;

  arp_msg_t msg_in, msg_q;

  assign msg_in = '{dst_mac: msg_dst_mac, src_mac: msg_src_mac,
                    oper: msg_oper, sha: msg_sender_mac, spa: msg_sender_ip,
                    tha: msg_target_mac, tpa: msg_target_ip};

  arp_tx_ctrl #(.BEATS(BEATS), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .msg_valid  (msg_valid),
    .hdr_ready  (hdr_ready),
    .beat_ready (body_tready),
    .msg_ready  (msg_ready),
    .msg_load   (msg_load),
    .hdr_valid  (hdr_valid),
    .hdr_fire   (hdr_fire),
    .beat_valid (body_tvalid),
    .beat_fire  (beat_fire),
    .beat_last  (body_tlast),
    .frame_done (frame_done),
    .beat_idx   (beat_idx),
    .busy       (busy)
  );

  arp_tx_capture u_cap (
    .clk    (clk),
    .rst    (rst),
    .load   (msg_load),
    .msg_in (msg_in),
    .msg_q  (msg_q)
  );

  arp_tx_beat_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_mux (
    .img      (body_image(msg_q)),
    .beat_idx (beat_idx),
    .tdata    (body_tdata),
    .tkeep    (body_tkeep)
  );

  assign hdr_dst_mac   = msg_q.dst_mac;
  assign hdr_src_mac   = msg_q.src_mac;
  assign hdr_ethertype = ETYPE_ARP;

endmodule

// File: rtl/arp_frame_tx_chk.sv
module arp_frame_tx_chk #(
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic                msg_load,
  input logic                hdr_valid,
  input logic                hdr_ready,
  input logic                hdr_fire,
  input logic [47:0]         hdr_dst_mac,
  input logic [47:0]         hdr_src_mac,
  input logic [15:0]         hdr_ethertype,
  input logic [DATA_W-1:0]   body_tdata,
  input logic [DATA_W/8-1:0] body_tkeep,
  input logic                body_tvalid,
  input logic                body_tready,
  input logic                body_tlast,
  input logic                frame_done,
  input logic                busy
);

  localparam int KEEP_W = DATA_W / 8;
  localparam int TAIL   = 28 - ((28 + KEEP_W - 1) / KEEP_W - 1) * KEEP_W;
  localparam logic [KEEP_W-1:0] TAIL_KEEP = KEEP_W'((64'd1 << TAIL) - 64'd1);

  a_r1_idle_ready: assert property (@(posedge clk) disable iff (rst)
    !busy |-> msg_ready);

  a_r2_no_ready_midframe: assert property (@(posedge clk) disable iff (rst)
    (busy && !frame_done) |-> !msg_ready);

  a_r3_hdr_hold: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_dst_mac) && $stable(hdr_src_mac)));

  a_r3_ethertype: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |-> (hdr_ethertype == 16'h0806));

  a_r3_hdr_after_load: assert property (@(posedge clk) disable iff (rst)
    msg_load |=> hdr_valid);

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(hdr_valid && body_tvalid));

  a_r4_body_follows_hdr: assert property (@(posedge clk) disable iff (rst)
    hdr_fire |=> (body_tvalid && !body_tlast));

  a_r7_last_keep: assert property (@(posedge clk) disable iff (rst)
    (body_tvalid && body_tlast) |-> (body_tkeep == TAIL_KEEP));

  a_r7_full_keep: assert property (@(posedge clk) disable iff (rst)
    (body_tvalid && !body_tlast) |-> (&body_tkeep));

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (body_tvalid && !body_tready) |=>
      (body_tvalid && $stable(body_tdata) && $stable(body_tkeep) && $stable(body_tlast)));

  a_r9_busy_after_load: assert property (@(posedge clk) disable iff (rst)
    msg_load |=> busy);

  a_r10_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (frame_done && msg_valid) |=> (hdr_valid && busy));

endmodule

bind arp_frame_tx arp_frame_tx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_arp_frame_tx.sv
module sim_arp_frame_tx;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 50000;

  logic        clk = 1'b0;
  logic        rst;
  logic        msg_valid;
  logic        msg_ready;
  logic [47:0] msg_dst_mac, msg_src_mac, msg_sender_mac, msg_target_mac;
  logic [15:0] msg_oper;
  logic [31:0] msg_sender_ip, msg_target_ip;
  logic        hdr_valid, hdr_ready;
  logic [47:0] hdr_dst_mac, hdr_src_mac;
  logic [15:0] hdr_ethertype;
  logic [63:0] body_tdata;
  logic [7:0]  body_tkeep;
  logic        body_tvalid, body_tready, body_tlast;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Reference model state
  int          m_mode = 0;     // 0 idle, 1 header, 2 body
  int          m_beat = 0;
  logic [47:0] m_dst, m_src;
  logic [7:0]  m_bytes[$];
  bit          m_directed = 0;
  bit          force_directed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arp_frame_tx u0 (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_field(logic [47:0] v, int nbytes);
    for (int i = nbytes - 1; i >= 0; i--) m_bytes.push_back(v[8*i +: 8]);
  endtask

  task automatic model_capture();
    m_dst = msg_dst_mac;
    m_src = msg_src_mac;
    m_directed = force_directed;
    m_bytes.delete();
    m_bytes.push_back(8'h00); m_bytes.push_back(8'h01);
    m_bytes.push_back(8'h08); m_bytes.push_back(8'h00);
    m_bytes.push_back(8'h06); m_bytes.push_back(8'h04);
    push_field({32'd0, msg_oper}, 2);
    push_field(msg_sender_mac, 6);
    push_field({16'd0, msg_sender_ip}, 4);
    push_field(msg_target_mac, 6);
    push_field({16'd0, msg_target_ip}, 4);
  endtask

  task automatic compare_outputs();
    logic [63:0] ed;
    logic [7:0]  ek;
    bit          exp_ready;
    exp_ready = (m_mode == 0) || (m_mode == 2 && m_beat == 3 && body_tready);
    check("R2/R10 msg_ready", {63'd0, msg_ready}, {63'd0, exp_ready});
    check("R9 busy", {63'd0, busy}, {63'd0, m_mode != 0});
    check("R3 hdr_valid", {63'd0, hdr_valid}, {63'd0, m_mode == 1});
    check("R4 body_tvalid", {63'd0, body_tvalid}, {63'd0, m_mode == 2});
    if (m_mode == 1) begin
      check("R3 hdr_dst_mac", {16'd0, hdr_dst_mac}, {16'd0, m_dst});
      check("R3 hdr_src_mac", {16'd0, hdr_src_mac}, {16'd0, m_src});
      check("R3 hdr_ethertype", {48'd0, hdr_ethertype}, 64'h0806);
    end
    if (m_mode == 2) begin
      ed = '0; ek = '0;
      for (int j = 0; j < 8; j++) begin
        int k;
        k = m_beat * 8 + j;
        if (k < m_bytes.size()) begin
          ed[8*j +: 8] = m_bytes[k];
          ek[j] = 1'b1;
        end
      end
      check("R5 body_tdata", body_tdata, ed);
      check("R7 body_tkeep", {56'd0, body_tkeep}, {56'd0, ek});
      check("R7 body_tlast", {63'd0, body_tlast}, {63'd0, m_beat == 3});
      if (m_directed && m_beat == 0)
        check("R6 beat0 constants", body_tdata, 64'h0200_0406_0008_0100);
      if (m_directed && m_beat == 3)
        check("R7 beat3 target ip", body_tdata, 64'h0000_0000_0100_A8C0);
    end
  endtask

  task automatic model_step();
    case (m_mode)
      0: if (msg_valid) begin model_capture(); m_mode = 1; end
      1: if (hdr_ready) begin m_mode = 2; m_beat = 0; end
      default: if (body_tready) begin
        if (m_beat == 3) begin
          if (msg_valid) begin model_capture(); m_mode = 1; end
          else m_mode = 0;
        end else m_beat++;
      end
    endcase
  endtask

  task automatic drive_fields();
    if (force_directed) begin
      msg_dst_mac    = 48'hFFFF_FFFF_FFFF;
      msg_src_mac    = 48'h0200_0000_0011;
      msg_oper       = 16'h0002;
      msg_sender_mac = 48'h0200_0000_0011;
      msg_sender_ip  = 32'hC0A8_0002;
      msg_target_mac = 48'h0600_0000_0022;
      msg_target_ip  = 32'hC0A8_0001;
    end else begin
      msg_dst_mac    = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      msg_src_mac    = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      msg_oper       = 16'($urandom);
      msg_sender_mac = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      msg_sender_ip  = $urandom;
      msg_target_mac = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      msg_target_ip  = $urandom;
    end
  endtask

  // pv/ph/pt: percent chance of msg_valid, hdr_ready, body_tready per cycle
  task automatic run_cycles(int n, int pv, int ph, int pt);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      drive_fields();
      msg_valid   = (($urandom % 100) < pv);
      hdr_ready   = (($urandom % 100) < ph);
      body_tready = (($urandom % 100) < pt);
      #1;
      compare_outputs();
      model_step();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; msg_valid = 1'b0; hdr_ready = 1'b0; body_tready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_mode = 0; m_beat = 0;
    #1;
    check("R1 reset msg_ready", {63'd0, msg_ready}, 64'd1);
    check("R1 reset hdr_valid", {63'd0, hdr_valid}, 64'd0);
    check("R1 reset body_tvalid", {63'd0, body_tvalid}, 64'd0);
    check("R1 reset busy", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; msg_valid = 1'b0; hdr_ready = 1'b0; body_tready = 1'b0;
    drive_fields();
    do_reset();
    // R6 R7 directed message, everything ready
    force_directed = 1;
    run_cycles(1, 100, 100, 100);
    force_directed = 0;
    run_cycles(8, 0, 100, 100);
    // R10 back-to-back with continuous ready
    run_cycles(400, 100, 100, 100);
    // R8 R3 random stalls on both outputs
    run_cycles(3000, 60, 50, 50);
    // R8 heavy body back-pressure
    run_cycles(2000, 80, 90, 15);
    // R1 reset in the middle of a frame
    run_cycles(3, 100, 100, 100);
    do_reset();
    // R2 sparse messages with fields changing every cycle
    run_cycles(2000, 20, 70, 70);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule